// File: doc/BRIEF.md
# Wide-to-Narrow Random Word FIFO

This block sits between a random block generator that produces 512-bit results and a consumer that takes 32-bit words. It stores up to four wide entries. It hands each entry out as sixteen narrow words over a valid/acknowledge handshake, starting with the most significant slice. It keeps the producer busy by raising a request whenever at least one wide entry is free.

On the input side, a one-cycle strobe carries a wide block in. The block accepts it only while the request is high. On the output side, the current word stays on the data port with valid high until the consumer acknowledges it. The sixteenth acknowledge of an entry frees that entry and moves to the next one in arrival order. A flush input throws away everything held and returns the block to its empty state in a single cycle.

Top module: `rnd_word_fifo`

## Requirements
- R1: After reset, `out_valid` is 0 and `more_req` is 1.
- R2: A block on `in_data` is stored at a rising edge where `in_valid` is 1, `flush` is 0 and fewer than four entries are held. `more_req` is 1 exactly when fewer than four entries are held.
- R3: An `in_valid` strobe while four entries are held is ignored. The held entries and their order are unchanged, and no fifth block is ever delivered.
- R4: `out_valid` is 1 exactly when at least one entry is held.
- R5: Each entry is delivered as sixteen words in this order: bits 511:480 first, then each next lower 32-bit slice, and bits 31:0 last. Each word stays on `out_data` with `out_valid` high until `out_ack` is 1 at a rising edge.
- R6: Entries are delivered in the order they were stored. The sixteenth acknowledge of an entry frees it, and the next word comes from the following entry.
- R7: `out_ack` while `out_valid` is 0 has no effect. The next block stored is still delivered from its top slice.
- R8: `flush` at a rising edge empties the block by that edge. After the edge, `out_valid` is 0 and `more_req` is 1. A block strobed in the same cycle is not stored.
- R9: After a flush, the first word delivered from a newly stored block is its top slice (bits 511:480), even if the flushed entry had been partly read.
- R10: A block stored into an empty FIFO is presented with `out_valid` at 1 right after the storing edge.
- R11: A write and the final acknowledge of the head entry in the same cycle both take effect. The entry count is unchanged, and the newly written block follows in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all held entries |
| in_valid | input | 1 | Producer strobe: `in_data` carries a block |
| in_data | input | 512 | Wide random block |
| more_req | output | 1 | Request for another block; high while an entry is free |
| out_valid | output | 1 | `out_data` holds a word |
| out_ack | input | 1 | Consumer takes the presented word |
| out_data | output | 32 | Current 32-bit word |

## Verification
The checker keeps its own count of held entries and its own slice position, worked out from the port handshakes alone. This relies on two things: that `in_valid` is a defined level, and that a strobe counts only while `more_req` is high. The checker also takes `out_data` to matter only while `out_valid` is high. Its hold and no-effect properties assume that no write lands on the head entry while that entry is presented. The bench drives every input to a known value half a cycle away from the active edge. It strobes a block while the FIFO is full only on purpose, to show that such a strobe is dropped.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

    // Default geometry shared by the FIFO and its checker
    localparam int unsigned RWF_IN_W  = 512;
    localparam int unsigned RWF_OUT_W = 32;
    localparam int unsigned RWF_DEPTH = 4;

    // What the control path does in a given cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_FLUSH = 2'd1,
        OP_MOVE  = 2'd2
    } rwf_op_e;

endpackage

// File: rtl/rwf_ctrl.sv
module rwf_ctrl #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned SLICES = 16,
    localparam int unsigned PTR_W = (DEPTH  > 1) ? $clog2(DEPTH)  : 1,
    localparam int unsigned SEL_W = (SLICES > 1) ? $clog2(SLICES) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    input  logic             out_ack,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [SEL_W-1:0] sel,
    output logic             empty,
    output logic             full
);
    import rwf_pkg::*;

    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(DEPTH);
    localparam logic [SEL_W-1:0] SEL_LAST  = SEL_W'(SLICES - 1);
    localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    rwf_op_e  op;
    logic     rd_en;
    logic     rd_last;

    always_comb begin
        st_d    = st_q;
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt == CNT_FULL);
        wr_en   = in_valid && !full && !flush;
        rd_en   = out_ack && !empty && !flush;
        rd_last = rd_en && (st_q.sel == SEL_LAST);

        if (flush)
            op = OP_FLUSH;
        else if (wr_en || rd_en)
            op = OP_MOVE;
        else
            op = OP_HOLD;

        unique case (op)
            OP_FLUSH: st_d = '0;
            OP_MOVE: begin
                if (wr_en)
                    st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + 1'b1;
                if (rd_en)
                    st_d.sel = (st_q.sel == SEL_LAST) ? '0 : st_q.sel + 1'b1;
                if (rd_last)
                    st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + 1'b1;
                if (wr_en && !rd_last)
                    st_d.cnt = st_q.cnt + 1'b1;
                else if (!wr_en && rd_last)
                    st_d.cnt = st_q.cnt - 1'b1;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign sel    = st_q.sel;

endmodule

// File: rtl/rwf_store.sv
module rwf_store #(
    parameter int unsigned IN_W   = 512,
    parameter int unsigned OUT_W  = 32,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned SLICES = IN_W / OUT_W,
    localparam int unsigned PTR_W  = (DEPTH  > 1) ? $clog2(DEPTH)  : 1,
    localparam int unsigned SEL_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [IN_W-1:0]  wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [SEL_W-1:0] sel,
    output logic [OUT_W-1:0] rd_word
);
    logic [IN_W-1:0]  ent_q [DEPTH];
    logic [IN_W-1:0]  ent_d [DEPTH];
    logic [IN_W-1:0]  head;
    logic [OUT_W-1:0] slice_w [SLICES];

    // One register per wide entry, loaded only when the write pointer selects it
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_comb begin
            ent_d[e] = ent_q[e];
            if (wr_en && (wr_ptr == PTR_W'(e)))
                ent_d[e] = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q[e] <= '0;
            else
                ent_q[e] <= ent_d[e];
        end
    end

    assign head = ent_q[rd_ptr];

    // Slice position 0 maps to the most significant word of the entry
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        assign slice_w[s] = head[(SLICES-1-s)*OUT_W +: OUT_W];
    end

    assign rd_word = slice_w[sel];

endmodule

// File: rtl/rnd_word_fifo.sv
module rnd_word_fifo #(
    parameter int unsigned IN_W  = rwf_pkg::RWF_IN_W,
    parameter int unsigned OUT_W = rwf_pkg::RWF_OUT_W,
    parameter int unsigned DEPTH = rwf_pkg::RWF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             more_req,
    output logic             out_valid,
    input  logic             out_ack,
    output logic [OUT_W-1:0] out_data
);
    localparam int unsigned SLICES = IN_W / OUT_W;
    localparam int unsigned PTR_W  = (DEPTH  > 1) ? $clog2(DEPTH)  : 1;
    localparam int unsigned SEL_W  = (SLICES > 1) ? $clog2(SLICES) : 1;

    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [SEL_W-1:0] sel;
    logic             empty;
    logic             full;

    rwf_ctrl #(
        .DEPTH  (DEPTH),
        .SLICES (SLICES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .in_valid (in_valid),
        .out_ack  (out_ack),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .sel      (sel),
        .empty    (empty),
        .full     (full)
    );

    rwf_store #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (in_data),
        .rd_ptr  (rd_ptr),
        .sel     (sel),
        .rd_word (out_data)
    );

    assign more_req  = !full;
    assign out_valid = !empty;

endmodule

// File: rtl/rnd_word_fifo_chk.sv
module rnd_word_fifo_chk #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned SLICES = 16,
    parameter int unsigned OUT_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             in_valid,
    input logic             more_req,
    input logic             out_valid,
    input logic             out_ack,
    input logic [OUT_W-1:0] out_data
);
    localparam int unsigned SH_W  = $clog2(DEPTH + 1) + 1;
    localparam int unsigned SEL_W = (SLICES > 1) ? $clog2(SLICES) : 1;
    localparam logic [SH_W-1:0]  SH_DEPTH = SH_W'(DEPTH);
    localparam logic [SEL_W-1:0] SEL_END  = SEL_W'(SLICES - 1);

    logic [SH_W-1:0]  sh_cnt;
    logic [SEL_W-1:0] sh_sel;
    logic             sh_wr;
    logic             sh_rd;
    logic             sh_last;

    assign sh_wr   = in_valid && more_req;
    assign sh_rd   = out_valid && out_ack;
    assign sh_last = sh_rd && (sh_sel == SEL_END);

    // Occupancy and slice position rebuilt from the port handshakes only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_cnt <= '0;
            sh_sel <= '0;
        end else if (flush) begin
            sh_cnt <= '0;
            sh_sel <= '0;
        end else begin
            if (sh_rd)
                sh_sel <= sh_sel + 1'b1;
            if (sh_wr && !sh_last)
                sh_cnt <= sh_cnt + 1'b1;
            else if (!sh_wr && sh_last)
                sh_cnt <= sh_cnt - 1'b1;
        end
    end

    p_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        more_req == (sh_cnt < SH_DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_cnt <= SH_DEPTH);

    p_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (sh_cnt != '0));

    p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack && !flush) |=> (out_valid && $stable(out_data)));

    p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !in_valid && !flush) |=> (!out_valid && $stable(out_data)));

    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_valid && more_req));

endmodule

bind rnd_word_fifo rnd_word_fifo_chk #(
    .DEPTH  (DEPTH),
    .SLICES (IN_W / OUT_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .more_req  (more_req),
    .out_valid (out_valid),
    .out_ack   (out_ack),
    .out_data  (out_data)
);

// File: tb/rnd_word_fifo_tb.sv
`timescale 1ns/1ps
module rnd_word_fifo_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] in_data = '0;
    logic         more_req;
    logic         out_valid;
    logic         out_ack = 1'b0;
    logic [31:0]  out_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rnd_word_fifo u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .more_req  (more_req),
        .out_valid (out_valid),
        .out_ack   (out_ack),
        .out_data  (out_data)
    );

    // Word k of block b; k = 0 is the most significant slice
    function automatic logic [31:0] wd(input logic [7:0] b, input int k);
        return {b, 8'(k), b ^ 8'h5a, 8'(15 - k)};
    endfunction

    function automatic logic [511:0] blk(input logic [7:0] b);
        logic [511:0] r;
        for (int k = 0; k < 16; k++)
            r[(15-k)*32 +: 32] = wd(b, k);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic push(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = blk(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop(input logic [7:0] b, input int k, input string tag);
        chk({tag, " valid"}, 32'(out_valid), 32'd1);
        chk({tag, " word"}, out_data, wd(b, k));
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
    endtask

    task automatic pop_block(input logic [7:0] b, input string tag);
        for (int k = 0; k < 16; k++)
            pop(b, k, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 more_req", 32'(more_req), 32'd1);
    endtask

    task automatic t_order();
        push(8'h01);
        chk("R10 valid after store", 32'(out_valid), 32'd1);
        push(8'h02);
        chk("R2 more_req with room", 32'(more_req), 32'd1);
        pop_block(8'h01, "R5 slice order");
        pop_block(8'h02, "R6 entry order");
        chk("R4 empty valid low", 32'(out_valid), 32'd0);
    endtask

    task automatic t_full();
        push(8'h20); push(8'h21); push(8'h22); push(8'h23);
        chk("R2 more_req full", 32'(more_req), 32'd0);
        push(8'h99);
        chk("R3 still full", 32'(more_req), 32'd0);
        pop_block(8'h20, "R3 entry0");
        chk("R2 room after free", 32'(more_req), 32'd1);
        pop_block(8'h21, "R3 entry1");
        pop_block(8'h22, "R3 entry2");
        pop_block(8'h23, "R3 entry3");
        chk("R3 no fifth block", 32'(out_valid), 32'd0);
    endtask

    task automatic t_idle_ack();
        out_ack = 1'b1;
        repeat (3) @(negedge clk);
        out_ack = 1'b0;
        chk("R7 valid stays low", 32'(out_valid), 32'd0);
        push(8'h05);
        pop_block(8'h05, "R7 top slice first");
        chk("R7 empty again", 32'(out_valid), 32'd0);
    endtask

    task automatic t_flush();
        push(8'h30); push(8'h31);
        pop(8'h30, 0, "R8 pre"); pop(8'h30, 1, "R8 pre"); pop(8'h30, 2, "R8 pre");
        flush    = 1'b1;
        in_valid = 1'b1;
        in_data  = blk(8'h66);
        @(negedge clk);
        flush    = 1'b0;
        in_valid = 1'b0;
        chk("R8 valid low", 32'(out_valid), 32'd0);
        chk("R8 more_req high", 32'(more_req), 32'd1);
        push(8'h07);
        pop_block(8'h07, "R9 after flush");
        chk("R8 strobe dropped", 32'(out_valid), 32'd0);
    endtask

    task automatic t_concurrent();
        push(8'h10);
        for (int k = 0; k < 15; k++)
            pop(8'h10, k, "R11 lead");
        chk("R11 last word", out_data, wd(8'h10, 15));
        out_ack  = 1'b1;
        in_valid = 1'b1;
        in_data  = blk(8'h11);
        @(negedge clk);
        out_ack  = 1'b0;
        in_valid = 1'b0;
        chk("R11 valid", 32'(out_valid), 32'd1);
        pop_block(8'h11, "R11 next block");
        chk("R11 empty", 32'(out_valid), 32'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_idle_ack();
        t_flush();
        t_concurrent();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule